// File: doc/BRIEF.md
# Element-Width Converting Vector Repacker

The block reads a run of vector elements packed at one element width in a stream of 64-bit source words. It writes them back out as 64-bit register writes packed at a second, independently chosen element width. Each source word is cut into elements, lowest-numbered element in the lowest bytes. Each element is zero-extended when the destination width is larger and truncated to its low bytes when it is smaller. The results are then laid end to end across consecutive destination registers, starting at a base register index, as if those registers were one contiguous block of bytes.

A run begins with a one-cycle `start` pulse. That pulse captures both width codes, the element count and the base register. Source words arrive over a valid/ready handshake. Every register write carries per-byte enables. The final, possibly partial register therefore only writes the bytes that hold elements, and its upper bytes keep their earlier contents. A one-cycle `done` pulse ends the run.

The controller has five states:
- IDLE waits for `start`. It goes to FETCH, or to FINISH when the count is zero.
- FETCH holds `src_ready` high and moves to PACK when a word is accepted.
- PACK places one element per cycle. It goes to WRITE when the destination register is full or the last element has been placed. Otherwise it goes back to FETCH when the source word is used up, or stays in PACK.
- WRITE issues one register write. After that it goes to FINISH if the last element was in this write, to FETCH if the source word is used up, and to PACK otherwise.
- FINISH raises `done` and returns to IDLE.

Top module: `vec_width_repacker`

## Requirements
- R1: Width codes are 2 bits (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit). Widths, count and base are captured on `start` in IDLE. Changing these inputs during a run has no effect on that run.
- R2: Source element k of a word occupies bytes k*S to k*S+S-1, where S is the source element size in bytes. Element n of the run is taken from source word n/(8/S).
- R3: When the destination width exceeds the source width, each element is zero-extended. The bytes above the source size are written as 0.
- R4: When the destination width is below the source width, each element keeps only its low-order D bytes, where D is the destination element size in bytes.
- R5: Destination element n is placed at byte offset n*D of a contiguous byte run that starts at byte 0 of register `base_reg`. Registers are written in increasing index order, one write per register.
- R6: The last write's byte enables cover exactly the bytes holding elements: the low ((count*D) mod 8) bytes, or all eight when that is 0. The remaining bytes of that register keep their prior value.
- R7: Every write other than the last has all eight byte enables set.
- R8: Exactly ceil(count*S/8) source words are accepted. The unused slots of the final word are ignored, and no further word is taken after the run.
- R9: A count of 0 raises `done` in the cycle after `start` and produces no writes.
- R10: `src_ready` is low in every cycle in which a register write is pending or issued.
- R11: `done` is high for exactly one cycle, in the cycle right after the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run (sampled in IDLE only) |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| vl | input | VL_W | Element count, 0 to 64 |
| base_reg | input | REG_W | First destination register index |
| src_valid | input | 1 | Source word offered |
| src_data | input | 64 | Source word |
| src_ready | output | 1 | Source word accepted when high with `src_valid` |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | REG_W | Register index of the write |
| wr_data | output | 64 | Register write data |
| wr_be | output | 8 | Per-byte write enables |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
- An accepted word reaches the packer in the next cycle.
- Each element then spends one PACK cycle before it is visible in a write.
- `done` follows the last write by exactly one cycle, and with a count of zero it follows `start` by one cycle.
- The bench drives inputs 2 ns after the falling edge and samples outputs on the falling edge, so every sample falls between the edges that produce it. A monitor logs each write and the cycle it occurs in into a modelled register file. Each scenario compares that file, the write count, the last byte mask and the cycle gap between the final write and `done` against values built from the requirements.

// File: rtl/repack_pkg.sv
package repack_pkg;
    typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_t;
    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_PACK, S_WRITE, S_FINISH} rp_state_t;
    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = 8 * WORD_BYTES;

    function automatic logic [WORD_BITS-1:0] ew_mask(input ew_t e);
        case (e)
            EW8:     ew_mask = 64'h0000_0000_0000_00FF;
            EW16:    ew_mask = 64'h0000_0000_0000_FFFF;
            EW32:    ew_mask = 64'h0000_0000_FFFF_FFFF;
            default: ew_mask = '1;
        endcase
    endfunction

    function automatic logic [WORD_BYTES-1:0] ew_be(input ew_t e);
        case (e)
            EW8:     ew_be = 8'h01;
            EW16:    ew_be = 8'h03;
            EW32:    ew_be = 8'h0F;
            default: ew_be = 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/repack_fsm.sv
module repack_fsm
    import repack_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       src_ew,
    input  logic [1:0]       dst_ew,
    input  logic [VL_W-1:0]  vl,
    input  logic [REG_W-1:0] base_reg,
    input  logic             src_valid,
    output logic             src_ready,
    output logic             load,
    output logic             pack,
    output logic             clr,
    output logic [2:0]       slot,
    output logic [2:0]       dpos,
    output ew_t              sew_q,
    output ew_t              dew_q,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic             wr_last,
    output logic             done
);
    rp_state_t        state, state_nx;
    logic [VL_W-1:0]  cnt, vl_q, cnt_inc;
    logic [REG_W-1:0] reg_q;
    logic             last_q;
    logic [3:0]       n_src, n_dst;
    logic [2:0]       slot_nx;
    logic             dst_full, is_last;

    assign n_src    = 4'd8 >> sew_q;
    assign n_dst    = 4'd8 >> dew_q;
    assign cnt_inc  = cnt + 1'b1;
    assign is_last  = (cnt_inc == vl_q);
    assign dst_full = (({1'b0, dpos} + 4'd1) == n_dst);
    assign slot_nx  = (({1'b0, slot} + 4'd1) == n_src) ? 3'd0 : slot + 3'd1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = (vl == '0) ? S_FINISH : S_FETCH;
            S_FETCH:  if (src_valid) state_nx = S_PACK;
            S_PACK:   if (is_last || dst_full) state_nx = S_WRITE;
                      else state_nx = (slot_nx == 3'd0) ? S_FETCH : S_PACK;
            S_WRITE:  if (last_q) state_nx = S_FINISH;
                      else state_nx = (slot == 3'd0) ? S_FETCH : S_PACK;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        src_ready = (state == S_FETCH);
        load      = (state == S_FETCH) && src_valid;
        pack      = (state == S_PACK);
        clr       = (state == S_WRITE);
        wr_en     = (state == S_WRITE);
        done      = (state == S_FINISH);
        wr_idx    = reg_q;
        wr_last   = last_q;
    end

    // run counters and latched parameters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; vl_q <= '0; reg_q <= '0; last_q <= 1'b0;
            slot <= '0; dpos <= '0; sew_q <= EW8; dew_q <= EW8;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    sew_q  <= ew_t'(src_ew);
                    dew_q  <= ew_t'(dst_ew);
                    vl_q   <= vl;
                    reg_q  <= base_reg;
                    cnt    <= '0;
                    slot   <= '0;
                    dpos   <= '0;
                    last_q <= 1'b0;
                end
                S_PACK: begin
                    cnt    <= cnt_inc;
                    slot   <= slot_nx;
                    dpos   <= dpos + 3'd1;
                    last_q <= is_last;
                end
                S_WRITE: begin
                    dpos  <= '0;
                    reg_q <= reg_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R9
    zero_run_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && vl == '0) |=> done);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    last_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |=> done);
    // R1
    widths_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(sew_q) && $stable(dew_q)));
    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack |-> ({1'b0, slot} < n_src));
endmodule

// File: rtl/src_slicer.sv
module src_slicer
    import repack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] word,
    input  logic [2:0]           slot,
    input  ew_t                  sew,
    input  ew_t                  dew,
    output logic [WORD_BITS-1:0] elem
);
    logic [WORD_BITS-1:0] hold;
    logic [6:0]           sh;

    always_ff @(posedge clk) begin
        if (!rst_n)    hold <= '0;
        else if (load) hold <= word;
    end

    assign sh   = {1'b0, slot, 3'b000} << sew;
    assign elem = (hold >> sh) & ew_mask(sew) & ew_mask(dew);
endmodule

// File: rtl/pack_accum.sv
module pack_accum
    import repack_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pack,
    input  logic                  clr,
    input  logic [WORD_BITS-1:0]  elem,
    input  logic [2:0]            dpos,
    input  ew_t                   dew,
    output logic [WORD_BITS-1:0]  acc,
    output logic [WORD_BYTES-1:0] be
);
    logic [2:0] bpos;
    logic [5:0] bitpos;

    assign bpos   = dpos << dew;
    assign bitpos = {bpos, 3'b000};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            be  <= '0;
        end else if (pack) begin
            acc <= acc | (elem << bitpos);
            be  <= be | (ew_be(dew) << bpos);
        end
    end
endmodule

// File: rtl/vec_width_repacker.sv
module vec_width_repacker
    import repack_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       src_ew,
    input  logic [1:0]       dst_ew,
    input  logic [VL_W-1:0]  vl,
    input  logic [REG_W-1:0] base_reg,
    input  logic             src_valid,
    input  logic [63:0]      src_data,
    output logic             src_ready,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [63:0]      wr_data,
    output logic [7:0]       wr_be,
    output logic             done
);
    logic       load, pack, clr, wr_last;
    logic [2:0] slot, dpos;
    ew_t        sew_q, dew_q;
    logic [WORD_BITS-1:0] elem;

    repack_fsm #(.VL_W(VL_W), .REG_W(REG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .src_ew(src_ew), .dst_ew(dst_ew),
        .vl(vl), .base_reg(base_reg), .src_valid(src_valid), .src_ready(src_ready),
        .load(load), .pack(pack), .clr(clr), .slot(slot), .dpos(dpos),
        .sew_q(sew_q), .dew_q(dew_q), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_last(wr_last), .done(done)
    );

    src_slicer u_slice (
        .clk(clk), .rst_n(rst_n), .load(load), .word(src_data), .slot(slot),
        .sew(sew_q), .dew(dew_q), .elem(elem)
    );

    pack_accum u_acc (
        .clk(clk), .rst_n(rst_n), .pack(pack), .clr(clr), .elem(elem),
        .dpos(dpos), .dew(dew_q), .acc(wr_data), .be(wr_be)
    );

    // R7
    full_write_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_last) |-> (wr_be == 8'hFF));
    // R6
    last_be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be[0] && (((wr_be + 8'd1) & wr_be) == 8'd0)));
    // R10
    ready_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !src_ready);
endmodule

// File: tb/sim_vec_width_repacker.sv
module sim_vec_width_repacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  src_ew = '0, dst_ew = '0;
    logic [6:0]  vl = '0;
    logic [4:0]  base_reg = '0;
    logic        src_valid = 1'b0;
    logic [63:0] src_data = '0;
    logic        src_ready, wr_en, done;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;

    int n_pass = 0, n_total = 0;

    always #10 clk = ~clk;

    vec_width_repacker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_ew(src_ew), .dst_ew(dst_ew),
        .vl(vl), .base_reg(base_reg), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_be(wr_be), .done(done)
    );

    function automatic logic [63:0] init_reg(input int r);
        return {8{8'(r * 29 + 7)}};
    endfunction

    function automatic logic [63:0] gen_word(input int seed, input int w);
        return {32'(seed * 32'h9E37_79B1) ^ 32'(w * 32'h0101_0101 + 1),
                32'(w * 32'h85EB_CA6B + seed * 7 + 3)};
    endfunction

    // write monitor: model register file and timing log
    logic [63:0] rf [32];
    int cyc, nwr, ndone, npart, rbad, last_wr_cyc, done_cyc;
    logic [7:0] last_be;
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 32; r++) rf[r] <= init_reg(r);
            cyc <= 0; nwr <= 0; ndone <= 0; npart <= 0; rbad <= 0;
            last_wr_cyc <= -10; done_cyc <= -1; last_be <= '0;
        end else begin
            cyc <= cyc + 1;
            if (wr_en) begin
                for (int b = 0; b < 8; b++)
                    if (wr_be[b]) rf[wr_idx][8*b +: 8] <= wr_data[8*b +: 8];
                nwr <= nwr + 1;
                last_wr_cyc <= cyc;
                last_be <= wr_be;
                if (wr_be != 8'hFF) npart <= npart + 1;
                if (src_ready) rbad <= rbad + 1;
            end
            if (done) begin
                ndone <= ndone + 1;
                done_cyc <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; src_valid = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic run_case(input int sew, input int dew, input int vl_i, input int base_i,
                            input int seed, input bit mix, input string tag);
        int ns, sb, db, nw, nregs, rem, extra, lo, hi;
        logic [7:0]  eb [256];
        logic [63:0] w, e, expr;
        logic [7:0]  exp_be;
        ns = 8 >> sew; sb = 1 << sew; db = 1 << dew;
        nw = (vl_i + ns - 1) / ns;
        nregs = (vl_i * db + 7) / 8;
        rem = (vl_i * db) % 8;
        exp_be = (rem == 0) ? 8'hFF : 8'((1 << rem) - 1);
        do_reset();
        for (int r = 0; r < 32; r++)
            for (int b = 0; b < 8; b++) eb[r*8+b] = init_reg(r) >> (8*b);
        for (int i = 0; i < vl_i; i++) begin
            w = gen_word(seed, i / ns);
            e = w >> ((i % ns) * sb * 8);
            for (int b = 0; b < db; b++)
                eb[base_i*8 + i*db + b] = (b < sb) ? e[8*b +: 8] : 8'h00;
        end
        start = 1'b1; src_ew = 2'(sew); dst_ew = 2'(dew); vl = 7'(vl_i); base_reg = 5'(base_i);
        step();
        start = 1'b0;
        if (mix) begin // R1: disturb the inputs mid-run
            src_ew = ~src_ew; dst_ew = ~dst_ew; vl = 7'd1; base_reg = 5'd0;
        end
        for (int k = 0; k < nw; k++) begin
            src_valid = 1'b1; src_data = gen_word(seed, k);
            while (!src_ready) step();
            step();
        end
        src_data = gen_word(seed, nw);
        extra = 0;
        for (int k = 0; k < 2000 && ndone == 0; k++) begin
            if (src_ready) extra++;
            step();
        end
        for (int k = 0; k < 3; k++) begin
            if (src_ready) extra++;
            step();
        end
        src_valid = 1'b0;
        chk(ndone == 1, "R11", 64'(ndone), 64'd1, {tag, " done pulses"});
        chk(done_cyc == last_wr_cyc + 1, "R11", 64'(done_cyc - last_wr_cyc), 64'd1,
            {tag, " done gap after last write"});
        chk(nwr == nregs, "R5", 64'(nwr), 64'(nregs), {tag, " write count"});
        chk(last_be == exp_be, "R6", 64'(last_be), 64'(exp_be), {tag, " last byte mask"});
        chk(npart == (rem != 0 ? 1 : 0), "R7", 64'(npart), 64'(rem != 0), {tag, " partial writes"});
        chk(rbad == 0, "R10", 64'(rbad), 64'd0, {tag, " ready during write"});
        chk(extra == 0, "R8", 64'(extra), 64'd0, {tag, " extra word taken"});
        lo = (base_i > 0) ? base_i - 1 : 0;
        hi = (base_i + nregs < 32) ? base_i + nregs : 31;
        for (int r = lo; r <= hi; r++) begin
            for (int b = 0; b < 8; b++) expr[8*b +: 8] = eb[r*8+b];
            chk(rf[r] == expr, mix ? "R1" : "R2/R3/R4/R5/R6", rf[r], expr,
                $sformatf("%s reg %0d", tag, r));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) step();
        chk(!wr_en, "R11", 64'(wr_en), 64'd0, "reset wr_en");
        chk(!done, "R11", 64'(done), 64'd0, "reset done");
        chk(!src_ready, "R10", 64'(src_ready), 64'd0, "reset ready");
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_widen_16_32();   run_case(1, 2, 7, 8, 1, 1'b0, "R3 16->32 vl7");   endtask
    task automatic t_widen_8_64();    run_case(0, 3, 5, 2, 2, 1'b0, "R3 8->64 vl5");    endtask
    task automatic t_narrow_64_8();   run_case(3, 0, 10, 20, 3, 1'b0, "R4 64->8 vl10"); endtask
    task automatic t_narrow_32_16();  run_case(2, 1, 3, 5, 4, 1'b0, "R4 32->16 vl3");   endtask
    task automatic t_same_16_64el();  run_case(1, 1, 64, 4, 5, 1'b0, "R7 16->16 vl64"); endtask
    task automatic t_bytes_8_8();     run_case(0, 0, 13, 0, 6, 1'b0, "R2 8->8 vl13");   endtask
    task automatic t_latched_inputs(); run_case(1, 2, 7, 8, 9, 1'b1, "R1 latched");     endtask

    task automatic t_zero_vl();
        do_reset();
        start = 1'b1; vl = 7'd0; base_reg = 5'd3; src_ew = 2'd1; dst_ew = 2'd2;
        step();
        start = 1'b0;
        chk(done, "R9", 64'(done), 64'd1, "done cycle after start");
        step();
        chk(!done, "R9", 64'(done), 64'd0, "done drops");
        step();
        chk(nwr == 0, "R9", 64'(nwr), 64'd0, "no writes");
        chk(rf[3] == init_reg(3), "R9", rf[3], init_reg(3), "base reg untouched");
    endtask

    initial begin
        #(20 * 200000);
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        t_reset();
        t_widen_16_32();
        t_widen_8_64();
        t_narrow_64_8();
        t_narrow_32_16();
        t_same_16_64el();
        t_bytes_8_8();
        t_latched_inputs();
        t_zero_vl();
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule